// File: doc/BRIEF.md
# Clock Divider Counter Field Encoder

This block turns a requested divide ratio into the counter-control fields that program one divider of a clock-synthesis tile. The request is an integer divider plus a fractional part counted in eighths (0 to 7). From it the block derives the high and low phase counts, the odd-count edge bit, the bypass (no-count) bit, the fractional enable and value, the rising and falling waveform-adjust bits and the fractional phase. It also assembles those fields into the three 16-bit configuration words that a divider takes.

A request is offered with a one-cycle valid strobe. One clock later the fields and words appear together with an output valid pulse. They hold until the next request. A divider of zero is not a legal ratio. It raises an error flag and produces all-zero fields.

Top module: `div_param_encoder`

## Requirements
- R1: A divider of 0 gives out_err = 1 and every field and every word equal to zero.
- R2: A divider of 1 gives out_nocount = 1 with every other field zero and out_err = 0, whatever the fraction input.
- R3: With a divider of 2 or more and fraction 0, high = divider/2 (rounded down), edge = divider mod 2, low = divider - high, and the fractional enable, fraction, waveform bits and phase are zero.
- R4: With a divider of 2 or more and a nonzero fraction, frac_en = 1, out_frac equals the fraction, edge = divider mod 2, and high = divider/2, less one when edge is 0.
- R5: The rising waveform bit is 1 exactly when the fractional mode is active and edge is 0.
- R6: In fractional mode, low = divider/2, less one when edge is 0 or the fraction is 1.
- R7: In fractional mode, the falling waveform bit is 1 when exactly one of (edge is 0) and (fraction is 1) is true, or when the divider is 2 and the fraction is 1. Otherwise it is 0.
- R8: The fractional phase equals 4*edge + fraction/2 (rounded down) in fractional mode and is 0 otherwise.
- R9: out_word0 carries the low 6 bits of high in bits 11:6 and the low 6 bits of low in bits 5:0, with zeros elsewhere.
- R10: out_word1 carries the fraction in bits 14:12, frac_en in bit 11, the rising waveform bit in bit 10, edge in bit 7 and nocount in bit 6, with zeros elsewhere.
- R11: out_word2 carries the phase in bits 13:11 and the falling waveform bit in bit 10, with zeros elsewhere.
- R12: out_valid is high in the cycle after each cycle with in_valid high, and only then. The fields and words of that request are present in the same cycle.
- R13: After synchronous reset every output is zero. While in_valid is low, all field and word outputs keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_div | input | 8 | Integer divider |
| in_frac | input | 3 | Fraction in eighths |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_err | output | 1 | Divider of zero was requested |
| out_high | output | 8 | High phase count |
| out_low | output | 8 | Low phase count |
| out_edge | output | 1 | Odd-count edge bit |
| out_nocount | output | 1 | Counter bypass |
| out_frac_en | output | 1 | Fractional mode enable |
| out_frac | output | 3 | Fractional value |
| out_wf_rise | output | 1 | Rising waveform adjust |
| out_wf_fall | output | 1 | Falling waveform adjust |
| out_phase | output | 3 | Fractional phase |
| out_word0 | output | 16 | Count word |
| out_word1 | output | 16 | Control word |
| out_word2 | output | 16 | Phase word |

## Verification
All state lives in one output register stage, so a wrong register value shows at the ports in the very cycle of the result strobe. It also stays visible until the next request, which is why idle cycles are checked against the last result. Fault decode of the mode (bypass, integer, fractional) shows as wrong count fields and wrong words in the first result after the request. Requests at the mode boundaries are used: dividers 0, 1 and 2, fraction 1, and both parities of the divider. A slip in the strobe register shows as a missing or extra result in the scoreboard within one cycle.

// File: rtl/divenc_pkg.sv
// Package: shared widths, word bit positions and the field bundle for the
// divider counter field encoder.
package divenc_pkg;
    parameter int DIV_W   = 8;   // integer divider width
    parameter int FRAC_W  = 3;   // fraction width (eighths)
    parameter int WORD_W  = 16;  // configuration word width
    parameter int CNTF_W  = 6;   // count width carried in a word

    // bit positions inside the configuration words
    parameter int W0_HIGH_LSB  = 6;
    parameter int W1_FRAC_LSB  = 12;
    parameter int W1_FEN_BIT   = 11;
    parameter int W1_WFR_BIT   = 10;
    parameter int W1_EDGE_BIT  = 7;
    parameter int W1_NOCNT_BIT = 6;
    parameter int W2_PHASE_LSB = 11;
    parameter int W2_WFF_BIT   = 10;

    typedef struct packed {
        logic              err;
        logic              nocount;
        logic [DIV_W-1:0]  high;
        logic [DIV_W-1:0]  low;
        logic              edge_b;
        logic              frac_en;
        logic [FRAC_W-1:0] frac;
        logic              wf_r;
        logic              wf_f;
        logic [FRAC_W-1:0] phase;
    } div_fields_t;
endpackage

// File: rtl/div_field_calc.sv
// div_field_calc: combinational mapping of a divider request (integer part
// plus eighths) to counter-control fields. Assumes inputs are stable for the
// cycle they are sampled; no state.
module div_field_calc
    import divenc_pkg::*;
(
    input  logic [DIV_W-1:0]  req_div,
    input  logic [FRAC_W-1:0] req_frac,
    output div_fields_t       fields
);
    logic [DIV_W-1:0] half;
    logic             odd;
    logic             frac_one;

    // helper terms shared by every mode
    always_comb begin
        half     = req_div >> 1;
        odd      = req_div[0];
        frac_one = (req_frac == FRAC_W'(1));
    end

    // mode decode and field derivation
    always_comb begin
        fields = '0;
        if (req_div == '0) begin
            fields.err = 1'b1;
        end else if (req_div == DIV_W'(1)) begin
            fields.nocount = 1'b1;
        end else if (req_frac == '0) begin
            fields.high   = half;
            fields.edge_b = odd;
            fields.low    = req_div - half;
        end else begin
            fields.frac_en = 1'b1;
            fields.frac    = req_frac;
            fields.edge_b  = odd;
            fields.high    = odd ? half : half - DIV_W'(1);
            fields.wf_r    = ~odd;
            fields.low     = (~odd | frac_one) ? half - DIV_W'(1) : half;
            fields.wf_f    = ((~odd) ^ frac_one) |
                             ((req_div == DIV_W'(2)) & frac_one);
            fields.phase   = {odd, req_frac[FRAC_W-1:1]};
        end
    end
endmodule

// File: rtl/div_word_pack.sv
// div_word_pack: places counter fields into the three configuration words.
// Assumes counts wider than the word slot are truncated to their low bits.
module div_word_pack
    import divenc_pkg::*;
(
    input  div_fields_t        fields,
    output logic [WORD_W-1:0]  word0,
    output logic [WORD_W-1:0]  word1,
    output logic [WORD_W-1:0]  word2
);
    // assemble each word from its fields at fixed bit positions
    always_comb begin
        word0 = '0;
        word0[W0_HIGH_LSB +: CNTF_W] = fields.high[CNTF_W-1:0];
        word0[0 +: CNTF_W]           = fields.low[CNTF_W-1:0];

        word1 = '0;
        word1[W1_FRAC_LSB +: FRAC_W] = fields.frac;
        word1[W1_FEN_BIT]            = fields.frac_en;
        word1[W1_WFR_BIT]            = fields.wf_r;
        word1[W1_EDGE_BIT]           = fields.edge_b;
        word1[W1_NOCNT_BIT]          = fields.nocount;

        word2 = '0;
        word2[W2_PHASE_LSB +: FRAC_W] = fields.phase;
        word2[W2_WFF_BIT]             = fields.wf_f;
    end
endmodule

// File: rtl/div_param_encoder.sv
// div_param_encoder: registered divider counter field encoder. Samples a
// request on in_valid, presents fields and packed words one cycle later with
// out_valid, and holds them until the next request. Synchronous active-low
// reset clears every output.
module div_param_encoder
    import divenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_div,
    input  logic [2:0]        in_frac,
    output logic              out_valid,
    output logic              out_err,
    output logic [7:0]        out_high,
    output logic [7:0]        out_low,
    output logic              out_edge,
    output logic              out_nocount,
    output logic              out_frac_en,
    output logic [2:0]        out_frac,
    output logic              out_wf_rise,
    output logic              out_wf_fall,
    output logic [2:0]        out_phase,
    output logic [15:0]       out_word0,
    output logic [15:0]       out_word1,
    output logic [15:0]       out_word2
);
    div_fields_t next_f;
    div_fields_t held_f;
    logic        valid_q;

    div_field_calc u_calc (
        .req_div  (in_div),
        .req_frac (in_frac),
        .fields   (next_f)
    );

    // capture the request result and the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_f  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) held_f <= next_f;
        end
    end

    div_word_pack u_pack (
        .fields (held_f),
        .word0  (out_word0),
        .word1  (out_word1),
        .word2  (out_word2)
    );

    // fan the held fields out to the ports
    always_comb begin
        out_valid   = valid_q;
        out_err     = held_f.err;
        out_high    = held_f.high;
        out_low     = held_f.low;
        out_edge    = held_f.edge_b;
        out_nocount = held_f.nocount;
        out_frac_en = held_f.frac_en;
        out_frac    = held_f.frac;
        out_wf_rise = held_f.wf_r;
        out_wf_fall = held_f.wf_f;
        out_phase   = held_f.phase;
    end

    assert_err_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_high == '0 && out_low == '0 && !out_nocount &&
                     !out_frac_en && out_word0 == '0 && out_word1 == '0 &&
                     out_word2 == '0));

    assert_bypass_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_nocount |-> (!out_err && out_high == '0 && out_low == '0 &&
                         !out_edge && !out_frac_en && out_phase == '0));

    assert_int_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_div > 8'd1 && in_frac == '0) |=>
        (out_high + out_low == $past(in_div)));

    assert_frac_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_frac_en |-> (out_frac != '0));

    assert_wf_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_wf_rise |-> (out_frac_en && !out_edge));

    assert_phase_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_frac_en |-> (out_phase[2] == out_edge));

    assert_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_stray_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |->
        ($stable(out_word0) && $stable(out_word1) && $stable(out_word2) &&
         $stable(out_err)));
endmodule

// File: tb/tb_div_param_encoder.sv
module tb_div_param_encoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_div = '0;
    logic [2:0]  in_frac = '0;
    logic        out_valid, out_err, out_edge, out_nocount, out_frac_en;
    logic        out_wf_rise, out_wf_fall;
    logic [7:0]  out_high, out_low;
    logic [2:0]  out_frac, out_phase;
    logic [15:0] out_word0, out_word1, out_word2;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct packed {
        logic        err, nocount, edge_b, frac_en, wf_r, wf_f;
        logic [7:0]  high, low;
        logic [2:0]  frac, phase;
        logic [15:0] w0, w1, w2;
    } exp_t;

    exp_t q[$];
    exp_t last_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    div_param_encoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_div(in_div),
        .in_frac(in_frac), .out_valid(out_valid), .out_err(out_err),
        .out_high(out_high), .out_low(out_low), .out_edge(out_edge),
        .out_nocount(out_nocount), .out_frac_en(out_frac_en),
        .out_frac(out_frac), .out_wf_rise(out_wf_rise),
        .out_wf_fall(out_wf_fall), .out_phase(out_phase),
        .out_word0(out_word0), .out_word1(out_word1), .out_word2(out_word2)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected result worked out from the requirements
    function automatic exp_t model(input int d, input int f);
        exp_t e = '0;
        int h, l;
        bit ev, f1;
        if (d == 0) begin
            e.err = 1;                                   // R1
        end else if (d == 1) begin
            e.nocount = 1;                               // R2
        end else if (f == 0) begin
            h = d / 2;                                   // R3
            e.high = 8'(h); e.low = 8'(d - h); e.edge_b = 1'(d % 2);
        end else begin
            ev = (d % 2 == 0); f1 = (f == 1);
            e.frac_en = 1; e.frac = 3'(f); e.edge_b = !ev;           // R4
            h = d / 2 - (ev ? 1 : 0);
            l = d / 2 - ((ev || f1) ? 1 : 0);                        // R6
            e.high = 8'(h); e.low = 8'(l);
            e.wf_r = ev;                                             // R5
            e.wf_f = (ev != f1) || (d == 2 && f1);                   // R7
            e.phase = 3'((ev ? 0 : 4) + f / 2);                      // R8
        end
        e.w0 = 16'((int'(e.high) % 64) * 64 + int'(e.low) % 64);    // R9
        e.w1 = 16'(int'(e.frac) * 4096 + int'(e.frac_en) * 2048 +
                   int'(e.wf_r) * 1024 + int'(e.edge_b) * 128 +
                   int'(e.nocount) * 64);                            // R10
        e.w2 = 16'(int'(e.phase) * 2048 + int'(e.wf_f) * 1024);      // R11
        return e;
    endfunction

    task automatic compare(input exp_t e, input string tag);
        chk("R1", {tag, " err"}, out_err, e.err);
        chk("R2", {tag, " nocount"}, out_nocount, e.nocount);
        chk("R3", {tag, " high"}, out_high, e.high);
        chk("R6", {tag, " low"}, out_low, e.low);
        chk("R4", {tag, " edge"}, out_edge, e.edge_b);
        chk("R4", {tag, " frac_en"}, out_frac_en, e.frac_en);
        chk("R4", {tag, " frac"}, out_frac, e.frac);
        chk("R5", {tag, " wf_rise"}, out_wf_rise, e.wf_r);
        chk("R7", {tag, " wf_fall"}, out_wf_fall, e.wf_f);
        chk("R8", {tag, " phase"}, out_phase, e.phase);
        chk("R9", {tag, " word0"}, out_word0, e.w0);
        chk("R10", {tag, " word1"}, out_word1, e.w1);
        chk("R11", {tag, " word2"}, out_word2, e.w2);
    endtask

    // driver: one request, expected item pushed to the scoreboard
    task automatic send(input int d, input int f);
        @(negedge clk);
        in_valid = 1'b1;
        in_div   = 8'(d);
        in_frac  = 3'(f);
        q.push_back(model(d, f));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: pop and compare on every result strobe (R12)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk("R12", "unexpected out_valid", 1, 0);
                end else begin
                    last_exp = q.pop_front();
                    compare(last_exp, "result");
                end
            end else if (q.size() > 1) begin
                chk("R12", "missing out_valid", 0, 1);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state (R13)
        chk("R13", "reset valid", out_valid, 0);
        chk("R13", "reset word0", out_word0, 0);
        chk("R13", "reset word1", out_word1, 0);
        chk("R13", "reset word2", out_word2, 0);
        chk("R13", "reset high", out_high, 0);
        rst_n = 1'b1;

        send(0, 3);    // R1 zero divider
        send(1, 0);    // R2 bypass
        send(1, 5);    // R2 bypass ignores fraction
        send(2, 0);    // R3 even integer
        send(7, 0);    // R3 odd integer
        send(200, 0);  // R3 wide count, R9 truncation
        send(2, 1);    // R7 divider-2 fraction-1 corner
        send(3, 1);    // R6 odd with fraction 1
        send(4, 3);    // R5 even fractional
        send(5, 4);    // R8 odd fractional phase
        send(9, 7);
        send(10, 1);
        send(255, 6);

        // back-to-back requests (R12)
        @(negedge clk);
        in_valid = 1'b1; in_div = 8'd6; in_frac = 3'd2; q.push_back(model(6, 2));
        @(negedge clk);
        in_div = 8'd11; in_frac = 3'd0; q.push_back(model(11, 0));
        @(negedge clk);
        in_valid = 1'b0; in_div = 8'd0; in_frac = 3'd1;

        // idle with changing inputs: outputs hold (R13)
        repeat (4) begin
            @(negedge clk);
            in_div = in_div + 8'd3;
            chk("R12", "idle valid", out_valid, 0);
            chk("R13", "hold word0", out_word0, last_exp.w0);
            chk("R13", "hold word1", out_word1, last_exp.w1);
            chk("R13", "hold high", out_high, last_exp.high);
        end

        repeat (2) @(negedge clk);
        chk("R12", "scoreboard drained", q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule